// File: doc/BRIEF.md
# Dynamic Reference Transfer Gate

This block sits beside a fast analog array that is read one column vector at a time. Each cycle a read vector may arrive, one signed sample per element. The block owns the chopper that modulates those reads. It removes the chopper sign from every sample and gathers, for each element, the sum and the sum of squares of the samples over the current chopper half-period. A half-period lasts a fixed power-of-two number of valid reads.

When the last read of a half-period is taken, three things happen at once. The block forms the half-period mean and compares it with the mean kept from the half-period before. It forms the spread of the samples, which is n times the sum of squares minus the square of the sum. It then judges whether the mean difference stands clear of the standard error of the mean. If it does, the block emits a transfer amount proportional to that difference, for the slow array. The new mean replaces the old one, and the accumulators restart with no lost cycle. The only reference is the previous half-period of reads, so no baseline array is kept.

Top module: `dyn_ref_gate`

## Requirements
- R1: Each sample is negated before accumulation when `chop_sign` is 1 and taken as is when it is 0. A read stream that follows the chopper sign therefore yields equal means in every half-period.
- R2: A half-period is 2^L valid reads, where L is `cfg_hp_log` clamped to the range 1..6 (0 acts as 1, 7 acts as 6). `chop_sign` is 0 after reset and toggles at the clock edge that takes the last valid read of a half-period. Cycles with `rd_valid` low do not count.
- R3: `hp_done` is high for exactly the one cycle after the edge that takes the last read of a half-period, and low otherwise.
- R4: The half-period mean is floor(S/n), with S the sum of demodulated samples and n = 2^L. The transfer amount of an element is floor((new mean − old mean) / 2^XFER_SHIFT), with XFER_SHIFT defaulting to 1. It is presented as a two's-complement value of RD_W+8 bits.
- R5: An element's `xfer_fire` bit is set when diff²·n³ > K·(n·Q − S²). Here diff is the mean difference, Q is the sum of squared demodulated samples of the new half-period, and K is `cfg_k2` taken as an unsigned value.
- R6: At the first half-period boundary after reset, no element fires and every amount is zero.
- R7: The read that ends a half-period belongs to that half-period. The next valid read starts the new half-period from cleared accumulators. Idle cycles between reads change nothing.
- R8: `xfer_fire` and `xfer_amt` are zero in every cycle where `hp_done` is low. An element's amount is zero whenever its fire bit is low.
- R9: While reset is held, `chop_sign`, `hp_done`, `xfer_fire` and `xfer_amt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | A read vector is present this cycle |
| rd_vec | input | N_ELEM*RD_W | Signed samples of the elements, element i at bits i*RD_W upward |
| cfg_hp_log | input | 3 | Log2 of the half-period length, clamped to 1..6 |
| cfg_k2 | input | 8 | Squared gate factor, unsigned |
| chop_sign | output | 1 | Chopper sign applied to the reads now being taken |
| hp_done | output | 1 | One-cycle pulse after a half-period closes |
| xfer_fire | output | N_ELEM | Per element, the mean difference passed the gate |
| xfer_amt | output | N_ELEM*(RD_W+8) | Signed transfer amounts, element i at bits i*(RD_W+8) upward |

## Verification
The boundary read does two jobs at one clock edge. It is accumulated into the closing half-period, and the accumulators clear and the chopper flips for the next half. The same edge also judges the gate on sums that include that final read. The bench provokes this with runs of back-to-back valid reads in which the first read of a new half follows the closing read with no gap. It also provokes it with runs where idle cycles fall just before or after a boundary. A model kept in plain integers judges each boundary's fire bits and amounts, and a single misplaced read changes the means, the spread or the chopper phase that the model predicts.

// File: rtl/dref_pkg.sv
package dref_pkg;

  localparam int MAX_LOG = 6;

  typedef logic [2:0] log_t;

  // legal half-period exponent: 1..MAX_LOG
  function automatic log_t clamp_log(input logic [2:0] cfg);
    if (cfg == 3'd0) return 3'd1;
    if (cfg > 3'(MAX_LOG)) return 3'(MAX_LOG);
    return cfg;
  endfunction

endpackage

// File: rtl/dref_phase.sv
module dref_phase
  import dref_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_valid,
  input  logic [2:0] cfg_hp_log,
  output logic       chop,
  output logic       last_read,
  output logic       armed,
  output log_t       hp_log
);

  logic [MAX_LOG-1:0] cnt_q;
  logic [MAX_LOG-1:0] cnt_lim;

  assign hp_log    = clamp_log(cfg_hp_log);
  assign cnt_lim   = (MAX_LOG'(1) << hp_log) - MAX_LOG'(1);
  assign last_read = rd_valid && (cnt_q == cnt_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      chop  <= 1'b0;
      armed <= 1'b0;
    end else if (last_read) begin
      cnt_q <= '0;
      chop  <= ~chop;
      armed <= 1'b1;
    end else if (rd_valid) begin
      cnt_q <= cnt_q + MAX_LOG'(1);
    end
  end

endmodule

// File: rtl/dref_lane.sv
module dref_lane
  import dref_pkg::*;
#(
  parameter int W          = 12,
  parameter int SW         = W + 8,
  parameter int XFER_SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  input  logic signed [W-1:0]  rd_val,
  input  logic                 chop,
  input  logic                 last_read,
  input  logic                 armed,
  input  log_t                 hp_log,
  input  logic [7:0]           k2,
  output logic                 fire,
  output logic signed [SW-1:0] amt
);

  localparam int DW  = W + 1;
  localparam int SQW = 2 * DW + MAX_LOG;
  localparam int CW  = 2 * SW + 20;

  // significance test without square root:
  // diff^2 * n^3 > k2 * (n*Q - S^2)
  function automatic logic gate_open(input logic signed [SW-1:0] df,
                                     input logic signed [SW-1:0] s,
                                     input logic [SQW-1:0]       q,
                                     input log_t                 lg,
                                     input logic [7:0]           k);
    logic signed [CW-1:0] dfe, se, qe, ke, spread, lhs, rhs;
    dfe    = CW'(df);
    se     = CW'(s);
    qe     = $signed(CW'(q));
    ke     = $signed(CW'(k));
    spread = (qe <<< lg) - se * se;
    lhs    = (dfe * dfe) <<< (3 * lg);
    rhs    = ke * spread;
    return lhs > rhs;
  endfunction

  logic signed [DW-1:0]   rd_ext, d;
  logic signed [2*DW-1:0] d2;
  logic signed [SW-1:0]   sum_q, sum_nx, old_q, new_mean, diff;
  logic [SQW-1:0]         sq_q, sq_nx;
  logic                   pass;

  assign rd_ext   = DW'(rd_val);
  assign d        = chop ? -rd_ext : rd_ext;
  assign d2       = d * d;
  assign sum_nx   = sum_q + SW'(d);
  assign sq_nx    = sq_q + SQW'($unsigned(d2));
  assign new_mean = sum_nx >>> hp_log;
  assign diff     = new_mean - old_q;
  assign pass     = gate_open(diff, sum_nx, sq_nx, hp_log, k2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sq_q  <= '0;
      old_q <= '0;
      fire  <= 1'b0;
      amt   <= '0;
    end else begin
      fire <= 1'b0;
      amt  <= '0;
      if (last_read) begin
        old_q <= new_mean;
        sum_q <= '0;
        sq_q  <= '0;
        if (armed && pass) begin
          fire <= 1'b1;
          amt  <= diff >>> XFER_SHIFT;
        end
      end else if (rd_valid) begin
        sum_q <= sum_nx;
        sq_q  <= sq_nx;
      end
    end
  end

endmodule

// File: rtl/dyn_ref_gate.sv
module dyn_ref_gate
  import dref_pkg::*;
#(
  parameter int N_ELEM     = 4,
  parameter int RD_W       = 12,
  parameter int XFER_SHIFT = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_valid,
  input  logic [N_ELEM*RD_W-1:0]       rd_vec,
  input  logic [2:0]                   cfg_hp_log,
  input  logic [7:0]                   cfg_k2,
  output logic                         chop_sign,
  output logic                         hp_done,
  output logic [N_ELEM-1:0]            xfer_fire,
  output logic [N_ELEM*(RD_W+8)-1:0]   xfer_amt
);

  localparam int AMT_W = RD_W + 8;

  logic last_read;
  logic armed;
  log_t hp_log;

  dref_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .cfg_hp_log (cfg_hp_log),
    .chop       (chop_sign),
    .last_read  (last_read),
    .armed      (armed),
    .hp_log     (hp_log)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hp_done <= 1'b0;
    else        hp_done <= last_read;
  end

  for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
    dref_lane #(
      .W          (RD_W),
      .SW         (AMT_W),
      .XFER_SHIFT (XFER_SHIFT)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_valid  (rd_valid),
      .rd_val    (rd_vec[g*RD_W +: RD_W]),
      .chop      (chop_sign),
      .last_read (last_read),
      .armed     (armed),
      .hp_log    (hp_log),
      .k2        (cfg_k2),
      .fire      (xfer_fire[g]),
      .amt       (xfer_amt[g*AMT_W +: AMT_W])
    );
  end

endmodule

// File: rtl/dyn_ref_gate_chk.sv
module dyn_ref_gate_chk #(
  parameter int N_ELEM = 4,
  parameter int AW     = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hp_done,
  input logic                   chop_sign,
  input logic [N_ELEM-1:0]      xfer_fire,
  input logic [N_ELEM*AW-1:0]   xfer_amt
);

  logic stray_amt;
  logic seen_done;

  always_comb begin
    stray_amt = 1'b0;
    for (int i = 0; i < N_ELEM; i++)
      if (!xfer_fire[i] && (xfer_amt[i*AW +: AW] != '0)) stray_amt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_done <= 1'b0;
    else if (hp_done) seen_done <= 1'b1;
  end

  // R3
  hp_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_done |=> !hp_done);

  // R2
  chop_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_done == (chop_sign != $past(chop_sign)));

  // R8
  fire_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_fire) |-> hp_done);

  // R8
  amt_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stray_amt);

  // R6
  first_half_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_done && !seen_done) |-> (xfer_fire == '0));

endmodule

bind dyn_ref_gate dyn_ref_gate_chk #(.N_ELEM(N_ELEM), .AW(AMT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hp_done   (hp_done),
  .chop_sign (chop_sign),
  .xfer_fire (xfer_fire),
  .xfer_amt  (xfer_amt)
);

// File: tb/dyn_ref_gate_test.sv
`timescale 1ns/1ps
module dyn_ref_gate_test;

  localparam int N  = 4;
  localparam int W  = 12;
  localparam int AW = W + 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_valid = 1'b0;
  logic [N*W-1:0]   rd_vec = '0;
  logic [2:0]       cfg_hp_log = 3'd1;
  logic [7:0]       cfg_k2 = 8'd0;
  logic             chop_sign;
  logic             hp_done;
  logic [N-1:0]     xfer_fire;
  logic [N*AW-1:0]  xfer_amt;

  always #2.5 clk = ~clk;

  dyn_ref_gate #(.N_ELEM(N), .RD_W(W), .XFER_SHIFT(1)) uut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_vec(rd_vec),
    .cfg_hp_log(cfg_hp_log), .cfg_k2(cfg_k2), .chop_sign(chop_sign),
    .hp_done(hp_done), .xfer_fire(xfer_fire), .xfer_amt(xfer_amt)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model, plain integers
  longint msum[N], msq[N], mold[N];
  int     mcnt, nlen, kval, hidx;
  bit     mchop, marmed;
  int     rv[N];
  string  tag;
  logic [15:0] lf = 16'hACE1;

  function automatic longint fdiv(longint a, longint b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  function automatic int clip(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int hp_cfg, int k);
    rst_n = 1'b0;
    rd_valid = 1'b0;
    cfg_hp_log = 3'(hp_cfg);
    cfg_k2 = 8'(k);
    kval = k;
    nlen = 1 << ((hp_cfg < 1) ? 1 : (hp_cfg > 6) ? 6 : hp_cfg);
    for (int i = 0; i < N; i++) begin msum[i] = 0; msq[i] = 0; mold[i] = 0; end
    mcnt = 0; mchop = 0; marmed = 0; hidx = 0;
    repeat (2) @(negedge clk);
    // R9 reset state while held
    check(chop_sign == 0 && hp_done == 0, "R9 chop/done in reset",
          {chop_sign, hp_done}, 0);
    check(xfer_fire == '0 && xfer_amt == '0, "R9 fire/amt in reset",
          longint'(xfer_fire), 0);
    rst_n = 1'b1;
  endtask

  // called at a negedge: drive one cycle, check at the following negedge
  task automatic step(bit v);
    bit     edone = 0;
    bit     efire[N];
    longint eamt[N];
    bit     was_armed = marmed;
    check(chop_sign == mchop, "R2 chop_sign", chop_sign, mchop);
    rd_valid = v;
    for (int i = 0; i < N; i++) begin
      rd_vec[i*W +: W] = W'(rv[i]);
      efire[i] = 0; eamt[i] = 0;
    end
    if (v) begin
      for (int i = 0; i < N; i++) begin
        longint dd = mchop ? -longint'(rv[i]) : longint'(rv[i]);
        msum[i] += dd;
        msq[i]  += dd * dd;
      end
      if (mcnt == nlen - 1) begin
        edone = 1;
        for (int i = 0; i < N; i++) begin
          longint nm = fdiv(msum[i], nlen);
          longint df = nm - mold[i];
          longint spread = longint'(nlen) * msq[i] - msum[i] * msum[i];
          bit gate = (df * df * nlen * nlen * nlen) > (longint'(kval) * spread);
          efire[i] = marmed && gate;
          eamt[i]  = efire[i] ? fdiv(df, 2) : 0;
          mold[i] = nm; msum[i] = 0; msq[i] = 0;
        end
        mchop = ~mchop; marmed = 1; mcnt = 0; hidx++;
      end else mcnt++;
    end
    @(negedge clk);
    check(hp_done == edone, "R3 hp_done", hp_done, edone);
    for (int i = 0; i < N; i++) begin
      longint a = longint'($signed(xfer_amt[i*AW +: AW]));
      check(xfer_fire[i] == efire[i],
            edone ? (was_armed ? {"R5 fire ", tag} : "R6 fire") : "R8 fire",
            xfer_fire[i], efire[i]);
      check(a == eamt[i], edone ? {"R4 amt ", tag} : "R8 amt", a, eamt[i]);
    end
  endtask

  task automatic make_vals(int p, int j);
    for (int i = 0; i < N; i++) begin
      int noise = (int'(lf[3:0]) - 8) * i;
      int base  = (hidx % 3) * 37 * (i + 1) - 50;
      case (p)
        1: begin
          int c = 100 * (i + 1) - 150 + (j % 2) * 0;
          rv[i] = mchop ? -c : c;
        end
        2: rv[i] = ((hidx + i) % 2 == 0) ? -2048 : 2047;
        default: rv[i] = clip(base + noise);
      endcase
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  initial begin : main
    int kset[4] = '{0, 1, 4, 16};
    @(negedge clk);
    for (int hc = 0; hc < 8; hc++)
      for (int ki = 0; ki < 4; ki++)
        for (int p = 0; p < 4; p++) begin
          case (p)
            0: tag = "R5 steps";
            1: tag = "R1 modulated";
            2: tag = "R4 extremes";
            default: tag = "R7 gaps";
          endcase
          if (hc == 0 || hc == 7) tag = {tag, " R2 clamp"};
          do_reset(hc, kset[ki]);
          for (int j = 0; j < 5 * nlen; j++) begin
            make_vals(p, j);
            if (p == 3 && (j % 3 == 1)) step(1'b0);
            step(1'b1);
          end
        end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule